// File: doc/BRIEF.md
# Iterative IEEE Remainder Unit

This block takes two single-precision floating-point numbers, a dividend `x` and a divisor `y`, and returns the exact IEEE remainder `x - Q*y`. Here `Q` is the real quotient `x/y` rounded to the nearest integer. Because `Q` is rounded and not truncated, the result carries a sign and its magnitude never exceeds half of `|y|`. The result is always exact, so no rounding-mode input exists and no inexact indication is produced.

An operation is offered by raising `start` for one cycle with both operands on the inputs while `busy` is low. Special operands (NaN, infinity, zero, or a dividend far below the divisor) are settled when the operands are accepted. For finite operands, the unit first normalises both significands. It then produces one quotient bit per clock by shift-and-subtract, over the exponent difference plus one. A final step rounds the quotient to nearest with ties to even and renormalises the exact remainder, including remainders that fall in the subnormal range. `done` pulses for one cycle with the result, the invalid and divide-by-zero flags, and the three lowest bits of `|Q|`.

Top module: `fprem_unit`

## Requirements
- R1: For finite nonzero operands, the result equals `x - Q*y`, where Q is `x/y` rounded to the nearest integer, and `|result| <= |y|/2`.
- R2: When `x/y` lies exactly halfway between two integers, Q is the even one of the two.
- R3: A zero result has the sign of the dividend (bit 31).
- R4: An infinite divisor with a finite or zero dividend returns the dividend bit for bit, with both flags low.
- R5: An infinite dividend with a non-NaN divisor, or a zero dividend with a zero divisor, raises `flag_invalid` and returns 0x7FC00000.
- R6: A finite nonzero dividend with a zero divisor of either sign raises `flag_divzero` and returns 0x7FC00000.
- R7: A zero dividend with a nonzero, non-NaN divisor returns that same signed zero with no flag.
- R8: A NaN operand (exponent field bits 30:23 all ones, fraction nonzero) yields that NaN with the quiet bit 22 set. The dividend's NaN is chosen if it has one, the divisor's otherwise. `flag_invalid` is raised only when an operand NaN has bit 22 clear (signaling).
- R9: Subnormal operands (exponent field zero) and subnormal results are handled exactly.
- R10: `quo_low` gives bits 2:0 of `|Q|`. When the dividend exponent lies more than one below that of the divisor, the dividend is returned with `quo_low` = 0.
- R11: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` pulses. `done` lasts one cycle. A `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Offer of a new operation; taken when `busy` is low |
| dividend | input | 32 | Single-precision dividend x |
| divisor | input | 32 | Single-precision divisor y |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; result and flags valid |
| result | output | 32 | Exact remainder or NaN |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_divzero | output | 1 | Divide-by-zero flag |
| quo_low | output | 3 | Bits 2:0 of the magnitude of Q |

## Verification
The two functions that can meet in one cycle are finishing one operation and accepting the next. `busy` falls on the same edge that raises `done`, so a `start` offered in the `done` cycle is taken at once. The bench's driver waits only for `busy` to be low, which offers each new operation in exactly that cycle. The scoreboard then judges by order: every `done` must match the oldest queued expectation, and an extra or missing pulse shows up as a mismatch or an empty queue. In addition, `start` is held high for several cycles during a long 150-step operation; no extra result may appear and the pending one must still be correct.

// File: rtl/fprem_pkg.sv
package fprem_pkg;

   typedef enum logic [2:0] {
      K_ZERO,
      K_FIN,
      K_INF,
      K_QNAN,
      K_SNAN
   } kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ITER,
      S_ROUND
   } phase_e;

endpackage

// File: rtl/fprem_unpack.sv
module fprem_unpack
   import fprem_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23,
   parameter int XW = EW + 3,
   parameter int LW = $clog2(MW + 2)
) (
   input  logic [EW+MW-1:0]     mag,
   output kind_e                kind,
   output logic [MW:0]          sig,
   output logic signed [XW-1:0] ex
);
   localparam int BIAS = (1 << (EW - 1)) - 1;

   logic [EW-1:0] ef;
   logic [MW-1:0] ff;
   logic [MW:0]   raw;
   logic [LW-1:0] lz;

   assign ef  = mag[EW+MW-1:MW];
   assign ff  = mag[MW-1:0];
   assign raw = {ef != '0, ff};

   always_comb begin
      if (ef == '1)
         kind = (ff == '0) ? K_INF : (ff[MW-1] ? K_QNAN : K_SNAN);
      else if (ef == '0 && ff == '0)
         kind = K_ZERO;
      else
         kind = K_FIN;
   end

   // distance of the leading one from the top significand bit
   always_comb begin
      lz = '0;
      for (int i = 0; i <= MW; i++)
         if (raw[i]) lz = LW'(MW - i);
   end

   assign sig = raw << lz;
   assign ex  = (ef == '0) ? XW'(1 - BIAS) - XW'(lz) : XW'(ef) - XW'(BIAS);
endmodule

// File: rtl/fprem_divstep.sv
module fprem_divstep #(
   parameter int MW = 23
) (
   input  logic [MW+1:0] rem,
   input  logic [MW:0]   dsig,
   output logic          ge,
   output logic [MW+1:0] nxt
);
   assign ge  = rem >= (MW+2)'(dsig);
   assign nxt = ge ? rem - (MW+2)'(dsig) : rem;
endmodule

// File: rtl/fprem_round_pack.sv
module fprem_round_pack #(
   parameter int EW = 8,
   parameter int MW = 23,
   parameter int XW = EW + 3,
   parameter int LW = $clog2(MW + 2)
) (
   input  logic [MW+1:0]        rem,
   input  logic                 q_lsb,
   input  logic [MW:0]          dsig,
   input  logic                 half,
   input  logic signed [XW-1:0] eb,
   input  logic                 sa,
   output logic                 up,
   output logic [EW+MW:0]       res
);
   localparam int BIAS = (1 << (EW - 1)) - 1;
   localparam int RW   = MW + 3;

   logic [RW-1:0]        rr, two_r, dv, dz;
   logic [MW:0]          mag;
   logic [LW-1:0]        p;
   logic signed [XW-1:0] s_ex, b_ex, k;
   logic [MW-1:0]        nm, sm;
   logic                 sgn;

   always_comb begin
      rr    = RW'(rem);
      dz    = RW'(dsig);
      two_r = half ? rr : rr << 1;
      dv    = half ? dz << 1 : dz;
      up    = (two_r > dz) || (two_r == dz && q_lsb);
      mag   = (MW+1)'(up ? dv - rr : rr);
   end

   always_comb begin
      p = '0;
      for (int i = 0; i <= MW; i++)
         if (mag[i]) p = LW'(i);
   end

   always_comb begin
      s_ex = eb - XW'(MW) - XW'(half);
      b_ex = s_ex + XW'(p) + XW'(BIAS);
      k    = s_ex + XW'(BIAS + MW - 1);
      nm   = MW'(mag << (LW'(MW) - p));
      sm   = k[XW-1] ? MW'(mag >> XW'(-k)) : MW'(mag << k);
      sgn  = (mag == '0) ? sa : sa ^ up;
      if (mag == '0)
         res = {sgn, {(EW+MW){1'b0}}};
      else if (!b_ex[XW-1] && b_ex != '0)
         res = {sgn, b_ex[EW-1:0], nm};
      else
         res = {sgn, {EW{1'b0}}, sm};
   end
endmodule

// File: rtl/fprem_unit.sv
module fprem_unit
   import fprem_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [EW+MW:0]      dividend,
   input  logic [EW+MW:0]      divisor,
   output logic                busy,
   output logic                done,
   output logic [EW+MW:0]      result,
   output logic                flag_invalid,
   output logic                flag_divzero,
   output logic [2:0]          quo_low
);
   localparam int FW = EW + MW + 1;
   localparam int XW = EW + 3;
   localparam int LW = $clog2(MW + 2);
   localparam logic [FW-1:0] QBIT  = FW'(1) << (MW - 1);
   localparam logic [FW-1:0] CANON = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
   localparam logic signed [XW-1:0] NEG1 = XW'(-1);

   if (EW < 4 || MW < 4) begin : g_param_chk
      $error("fprem_unit: EW and MW must both be at least 4");
   end

   kind_e                kind_v [2];
   logic [MW:0]          sig_v  [2];
   logic signed [XW-1:0] ex_v   [2];
   logic [FW-2:0]        mag_v  [2];

   assign mag_v[0] = dividend[FW-2:0];
   assign mag_v[1] = divisor[FW-2:0];

   for (genvar g = 0; g < 2; g++) begin : g_unp
      fprem_unpack #(.EW(EW), .MW(MW), .XW(XW), .LW(LW)) u_unp (
         .mag (mag_v[g]),
         .kind(kind_v[g]),
         .sig (sig_v[g]),
         .ex  (ex_v[g])
      );
   end

   phase_e               state;
   logic [MW+1:0]        rem;
   logic [MW:0]          dsig;
   logic signed [XW-1:0] eb;
   logic [XW-1:0]        cnt;
   logic [2:0]           q3;
   logic                 half, sa, spec, spec_inv, spec_dz;
   logic [FW-1:0]        spec_res;

   // settle special operand pairs at acceptance
   logic                 sp, sp_inv, sp_dz;
   logic [FW-1:0]        sp_res;
   logic signed [XW-1:0] dexp;
   logic                 a_nan, b_nan;

   always_comb begin
      dexp   = ex_v[0] - ex_v[1];
      a_nan  = kind_v[0] == K_QNAN || kind_v[0] == K_SNAN;
      b_nan  = kind_v[1] == K_QNAN || kind_v[1] == K_SNAN;
      sp     = 1'b1;
      sp_res = CANON;
      sp_inv = 1'b0;
      sp_dz  = 1'b0;
      if (a_nan) begin
         sp_res = dividend | QBIT;
         sp_inv = kind_v[0] == K_SNAN || kind_v[1] == K_SNAN;
      end else if (b_nan) begin
         sp_res = divisor | QBIT;
         sp_inv = kind_v[1] == K_SNAN;
      end else if (kind_v[0] == K_INF) begin
         sp_inv = 1'b1;
      end else if (kind_v[0] == K_ZERO) begin
         if (kind_v[1] == K_ZERO) sp_inv = 1'b1;
         else                     sp_res = dividend;
      end else if (kind_v[1] == K_ZERO) begin
         sp_dz = 1'b1;
      end else if (kind_v[1] == K_INF || dexp < NEG1) begin
         sp_res = dividend;
      end else begin
         sp = 1'b0;
      end
   end

   logic          st_ge;
   logic [MW+1:0] st_nxt;

   fprem_divstep #(.MW(MW)) u_step (
      .rem (rem),
      .dsig(dsig),
      .ge  (st_ge),
      .nxt (st_nxt)
   );

   logic          pk_up;
   logic [FW-1:0] pk_res;

   fprem_round_pack #(.EW(EW), .MW(MW), .XW(XW), .LW(LW)) u_pack (
      .rem  (rem),
      .q_lsb(q3[0]),
      .dsig (dsig),
      .half (half),
      .eb   (eb),
      .sa   (sa),
      .up   (pk_up),
      .res  (pk_res)
   );

   assign busy = state != S_IDLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= S_IDLE;
         rem          <= '0;
         dsig         <= '0;
         eb           <= '0;
         cnt          <= '0;
         q3           <= '0;
         half         <= 1'b0;
         sa           <= 1'b0;
         spec         <= 1'b0;
         spec_inv     <= 1'b0;
         spec_dz      <= 1'b0;
         spec_res     <= '0;
         done         <= 1'b0;
         result       <= '0;
         flag_invalid <= 1'b0;
         flag_divzero <= 1'b0;
         quo_low      <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               sa       <= dividend[FW-1];
               spec     <= sp;
               spec_res <= sp_res;
               spec_inv <= sp_inv;
               spec_dz  <= sp_dz;
               q3       <= '0;
               half     <= dexp == NEG1;
               rem      <= (MW+2)'(sig_v[0]);
               dsig     <= sig_v[1];
               eb       <= ex_v[1];
               cnt      <= dexp;
               state    <= (sp || dexp == NEG1) ? S_ROUND : S_ITER;
            end
            S_ITER: begin
               q3 <= {q3[1:0], st_ge};
               if (cnt == '0) begin
                  rem   <= st_nxt;
                  state <= S_ROUND;
               end else begin
                  rem <= st_nxt << 1;
                  cnt <= cnt - 1'b1;
               end
            end
            S_ROUND: begin
               done  <= 1'b1;
               state <= S_IDLE;
               if (spec) begin
                  result       <= spec_res;
                  flag_invalid <= spec_inv;
                  flag_divzero <= spec_dz;
                  quo_low      <= '0;
               end else begin
                  result       <= pk_res;
                  flag_invalid <= 1'b0;
                  flag_divzero <= 1'b0;
                  quo_low      <= q3 + {2'b00, pk_up};
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fprem_unit_chk.sv
module fprem_unit_chk #(
   parameter int EW = 8,
   parameter int MW = 23
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [EW+MW:0]   dividend,
   input logic [EW+MW:0]   divisor,
   input logic             busy,
   input logic             done,
   input logic [EW+MW:0]   result,
   input logic             flag_invalid,
   input logic             flag_divzero
);
   localparam int FW = EW + MW + 1;
   localparam logic [FW-1:0] QBIT  = FW'(1) << (MW - 1);
   localparam logic [FW-1:0] CANON = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

   logic [FW-1:0] cap_a, cap_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_a <= '0;
         cap_b <= '0;
      end else if (start && !busy) begin
         cap_a <= dividend;
         cap_b <= divisor;
      end
   end

   logic a_top, b_top, a_nan, b_nan, b_inf;
   assign a_top = &cap_a[FW-2:MW];
   assign b_top = &cap_b[FW-2:MW];
   assign a_nan = a_top && cap_a[MW-1:0] != '0;
   assign b_nan = b_top && cap_b[MW-1:0] != '0;
   assign b_inf = b_top && cap_b[MW-1:0] == '0;

   p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_zero_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done && result[FW-2:0] == '0 |-> result[FW-1] == cap_a[FW-1]);
   p_inf_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done && b_inf && !a_top |-> result == cap_a && !flag_invalid && !flag_divzero);
   p_invalid_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done && flag_invalid |-> &result[FW-2:MW] && result[MW-1]);
   p_divzero_canon_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done && flag_divzero |-> result == CANON && !flag_invalid);
   p_nan_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done && b_nan && !a_nan |-> result == (cap_b | QBIT));
endmodule

bind fprem_unit fprem_unit_chk #(.EW(EW), .MW(MW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .dividend    (dividend),
   .divisor     (divisor),
   .busy        (busy),
   .done        (done),
   .result      (result),
   .flag_invalid(flag_invalid),
   .flag_divzero(flag_divzero)
);

// File: tb/fprem_unit_bench.sv
`timescale 1ns/1ps
module fprem_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dividend = '0, divisor = '0;
   logic        busy, done, flag_invalid, flag_divzero;
   logic [31:0] result;
   logic [2:0]  quo_low;

   localparam logic [31:0] CANON = 32'h7FC0_0000;

   always #2.5 clk = ~clk;

   fprem_unit u_fprem_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .result(result), .flag_invalid(flag_invalid),
      .flag_divzero(flag_divzero), .quo_low(quo_low)
   );

   typedef struct {
      logic [31:0] res;
      logic [2:0]  q;
      logic        inv, dz;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   total = 0, bad = 0, n_done = 0, n_sent = 0;
   bit   ended = 0;

   function automatic exp_t mk(logic [31:0] r, logic [2:0] q, logic inv, logic dz, string tag);
      exp_t e;
      e.res = r; e.q = q; e.inv = inv; e.dz = dz; e.tag = tag;
      return e;
   endfunction

   function automatic logic [31:0] pack_val(logic s, logic [63:0] m, int lsb);
      int p, ex, sh;
      logic [63:0] f;
      if (m == 0) return {s, 31'b0};
      p = 0;
      for (int i = 0; i < 64; i++) if (m[i]) p = i;
      ex = lsb + p;
      if (ex >= -126) begin
         f = (p >= 23) ? m >> (p - 23) : m << (23 - p);
         return {s, 8'(ex + 127), f[22:0]};
      end
      sh = lsb + 149;
      f  = (sh >= 0) ? m << sh : m >> (-sh);
      return {s, 8'b0, f[22:0]};
   endfunction

   // independent model; finite path valid for LSB exponent gaps up to 38
   function automatic exp_t model(logic [31:0] a, logic [31:0] b, string tag);
      logic an, bn, ai, bi, az, bz, up;
      logic [63:0] ma, mb, aa, bb, qq, rr, mm;
      int la, lb, lo;
      an = &a[30:23] && a[22:0] != 0;  bn = &b[30:23] && b[22:0] != 0;
      ai = &a[30:23] && a[22:0] == 0;  bi = &b[30:23] && b[22:0] == 0;
      az = a[30:0] == 0;               bz = b[30:0] == 0;
      if (an) return mk(a | 32'h0040_0000, 0, !a[22] || (bn && !b[22]), 0, tag);
      if (bn) return mk(b | 32'h0040_0000, 0, !b[22], 0, tag);
      if (ai || (az && bz)) return mk(CANON, 0, 1, 0, tag);
      if (bz) return mk(CANON, 0, 0, 1, tag);
      if (az || bi) return mk(a, 0, 0, 0, tag);
      ma = (a[30:23] == 0) ? {41'b0, a[22:0]} : {40'b0, 1'b1, a[22:0]};
      mb = (b[30:23] == 0) ? {41'b0, b[22:0]} : {40'b0, 1'b1, b[22:0]};
      la = (a[30:23] == 0) ? -149 : int'(a[30:23]) - 150;
      lb = (b[30:23] == 0) ? -149 : int'(b[30:23]) - 150;
      lo = (la < lb) ? la : lb;
      aa = ma << (la - lo);
      bb = mb << (lb - lo);
      qq = aa / bb;
      rr = aa % bb;
      up = (2 * rr > bb) || (2 * rr == bb && qq[0]);
      mm = up ? bb - rr : rr;
      return mk(pack_val((mm == 0) ? a[31] : a[31] ^ up, mm, lo), 3'(qq + 64'(up)), 0, 0, tag);
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic send(logic [31:0] a, logic [31:0] b, exp_t e);
      @(negedge clk);
      while (busy) @(negedge clk);
      sb.push_back(e);
      n_sent++;
      dividend = a; divisor = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      total++;
      if (!busy) begin
         bad++;
         $display("FAIL R11 busy after accept act=0 exp=1 (%s)", e.tag);
      end
   endtask

   // monitor: pop and compare at every done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         n_done++;
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL R11 unexpected done act=1 exp=0 res=%h", result);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (result !== e.res || quo_low !== e.q || flag_invalid !== e.inv || flag_divzero !== e.dz) begin
               bad++;
               $display("FAIL %s act res=%h q=%0d inv=%0b dz=%0b exp res=%h q=%0d inv=%0b dz=%0b",
                        e.tag, result, quo_low, flag_invalid, flag_divzero, e.res, e.q, e.inv, e.dz);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (busy !== 1'b0 || done !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset busy/done act=%0b%0b exp=00", busy, done);
      end
      rst_n = 1'b1;

      // R1: nearest-integer quotient, signed result
      send(32'h4120_0000, 32'h4040_0000, model(32'h4120_0000, 32'h4040_0000, "R1 10 rem 3"));
      send(32'h4130_0000, 32'h4040_0000, model(32'h4130_0000, 32'h4040_0000, "R1 11 rem 3"));
      send(32'hC120_0000, 32'h4040_0000, model(32'hC120_0000, 32'h4040_0000, "R1 -10 rem 3"));
      send(32'h3F80_0000, 32'h3DCC_CCCD, model(32'h3F80_0000, 32'h3DCC_CCCD, "R1 1 rem 0.1"));
      // R2: ties to even, including one-exponent-below dividend
      send(32'h40A0_0000, 32'h4000_0000, mk(32'h3F80_0000, 2, 0, 0, "R2 5 rem 2"));
      send(32'h40E0_0000, 32'h4000_0000, mk(32'hBF80_0000, 4, 0, 0, "R2 7 rem 2"));
      send(32'h40C0_0000, 32'h4080_0000, mk(32'hC000_0000, 2, 0, 0, "R2 6 rem 4"));
      send(32'h3F00_0000, 32'h3F80_0000, mk(32'h3F00_0000, 0, 0, 0, "R2 0.5 rem 1"));
      send(32'h3F40_0000, 32'h3F80_0000, mk(32'hBE80_0000, 1, 0, 0, "R2 0.75 rem 1"));
      // R3: zero results keep dividend sign
      send(32'hC0C0_0000, 32'h4040_0000, mk(32'h8000_0000, 2, 0, 0, "R3 -6 rem 3"));
      send(32'h40C0_0000, 32'hC040_0000, mk(32'h0000_0000, 2, 0, 0, "R3 6 rem -3"));
      // R4: infinite divisor
      send(32'h40A0_0000, 32'h7F80_0000, mk(32'h40A0_0000, 0, 0, 0, "R4 5 rem inf"));
      send(32'h8000_0000, 32'hFF80_0000, mk(32'h8000_0000, 0, 0, 0, "R4 -0 rem -inf"));
      // R5: invalid cases
      send(32'h7F80_0000, 32'h4000_0000, mk(CANON, 0, 1, 0, "R5 inf rem 2"));
      send(32'hFF80_0000, 32'h7F80_0000, mk(CANON, 0, 1, 0, "R5 -inf rem inf"));
      send(32'h0000_0000, 32'h8000_0000, mk(CANON, 0, 1, 0, "R5 0 rem -0"));
      // R6: divide by zero
      send(32'h4040_0000, 32'h0000_0000, mk(CANON, 0, 0, 1, "R6 3 rem 0"));
      send(32'hBF80_0000, 32'h8000_0000, mk(CANON, 0, 0, 1, "R6 -1 rem -0"));
      // R7: zero dividend
      send(32'h8000_0000, 32'h4040_0000, mk(32'h8000_0000, 0, 0, 0, "R7 -0 rem 3"));
      send(32'h0000_0000, 32'h0000_0001, mk(32'h0000_0000, 0, 0, 0, "R7 0 rem tiny"));
      // R8: NaN propagation
      send(32'h7FC1_2345, 32'h3F80_0000, mk(32'h7FC1_2345, 0, 0, 0, "R8 qnan rem 1"));
      send(32'h3F80_0000, 32'hFF80_0001, mk(32'hFFC0_0001, 0, 1, 0, "R8 1 rem snan"));
      send(32'h7F80_0010, 32'h7F80_0000, mk(32'h7FC0_0010, 0, 1, 0, "R8 snan rem inf"));
      // R9: subnormals
      send(32'h0000_0005, 32'h0000_0002, mk(32'h0000_0001, 2, 0, 0, "R9 sub tie"));
      send(32'h00C0_0000, 32'h0080_0000, mk(32'h8040_0000, 2, 0, 0, "R9 sub result"));
      send(32'h0080_0001, 32'h0000_0003, model(32'h0080_0001, 32'h0000_0003, "R9 norm rem sub"));
      // R10: quotient low bits, long runs and tiny dividend
      send(32'h7180_0000, 32'h4040_0000, mk(32'h3F80_0000, 5, 0, 0, "R10 2^100 rem 3"));
      send(32'h7180_0000, 32'h40E0_0000, mk(32'h4000_0000, 2, 0, 0, "R10 2^100 rem 7"));
      send(32'h3F80_0000, 32'h5000_0000, mk(32'h3F80_0000, 0, 0, 0, "R10 1 rem 2^33"));
      // R11 with R9: long operation, start held while busy must be ignored
      send(32'h3F80_0000, 32'h0000_0003, mk(32'h8000_0001, 3, 0, 0, "R11 R9 1 rem 3 tiny"));
      dividend = 32'h40A0_0000; divisor = 32'h4000_0000;
      for (int i = 0; i < 3; i++) begin
         start = 1'b1;
         @(negedge clk);
         total++;
         if (!busy) begin
            bad++;
            $display("FAIL R11 busy during run act=0 exp=1");
         end
      end
      start = 1'b0;
      send(32'h4130_0000, 32'h4040_0000, model(32'h4130_0000, 32'h4040_0000, "R11 after ignore"));

      while (sb.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      total++;
      if (busy || done || n_done != n_sent) begin
         bad++;
         $display("FAIL R11 end state act busy=%0b dones=%0d exp busy=0 dones=%0d", busy, n_done, n_sent);
      end
      finish_run();
   end
endmodule